// File: doc/BRIEF.md
# Accumulator Data-Movement and Stack Unit

This unit carries out the register and memory moves of a small 8-bit accumulator machine. It owns two byte accumulators (A and B, which together read as the 16-bit pair D with A in the upper byte), two 16-bit index registers (X and Y), a 16-bit stack pointer and a four-flag condition register (N, Z, V, C). A sequencer that has already decoded an instruction and computed its effective address hands the unit one operation at a time. The operations are clear, load, store, register transfer, D/index exchange, stack push and stack pull.

Memory traffic goes over a byte-wide synchronous port. A read issued in one cycle returns its data in the next cycle. A 16-bit access takes two consecutive beats: the upper byte at the effective address, then the lower byte at the address after it. The stack sits in descending memory, and the stack pointer always names the next free byte. Each operation has its own fixed rule for updating the flags. The unit raises `done` for one cycle once all of an operation's results are visible.

Top module: `acc_move_unit`

## Requirements
- R1: After reset, A, B, X, Y and all four flags read zero, SP equals the SP_INIT parameter, `req_ready` is 1 and `done` is 0.
- R2: Clear (op 0) zeroes A (sel 0), B (sel 1) or the memory byte at `req_addr` (sel 2). It sets the flags to N=0, Z=1, V=0, C=0, which reads as `ccr` = 4'b0100, where `ccr` is {N,Z,V,C} from bit 3 down to bit 0.
- R3: Load (op 1) reads memory into A (sel 0), B (sel 1) or D (sel 2). For D, A takes the byte at `req_addr` and B takes the byte at `req_addr`+1. N is the loaded value's top bit, Z is set when the value is zero, V is cleared and C is kept.
- R4: Store (op 2) writes A (sel 0), B (sel 1) or D (sel 2) to memory. For D, A goes to `req_addr` and B to `req_addr`+1 in back-to-back beats. N and Z follow the stored value, V is cleared and C is kept.
- R5: Push (op 5) writes A (sel 0) or B (sel 1) at the address held in SP, and only afterwards decrements SP. The flags do not change.
- R6: Pull (op 6) first increments SP, then reads the byte at the new SP into A (sel 0) or B (sel 1). The flags do not change.
- R7: Transfer (op 3) sel 0 copies A into B, and sel 1 copies B into A. In both cases N and Z follow the copied byte, V is cleared and C is kept.
- R8: Transfer sel 2 loads the flags from A bits 3..0 (N from bit 3, Z from bit 2, V from bit 1, C from bit 0). Transfer sel 3 writes {4'b0000, N, Z, V, C} into A and leaves the flags as they were.
- R9: Exchange (op 4) swaps D with X (sel 0) or with Y (sel 1) in one step. The flags do not change.
- R10: `req_ready` is high only while the unit is idle, and a request presented while it is low is ignored. `done` pulses in the cycle after the final memory beat, which gives these latencies in clock edges from acceptance: 1 for register-only operations, 2 for a byte store, a memory clear or a push, 3 for a D store, a byte load or a pull, and 4 for a D load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code |
| req_sel | input | 2 | Operand / variant select |
| req_addr | input | AW | Effective address |
| req_ready | output | 1 | Unit idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | BW | Memory write data |
| mem_rdata | input | BW | Memory read data, one cycle after `mem_re` |
| acc_a | output | BW | Accumulator A |
| acc_b | output | BW | Accumulator B |
| idx_x | output | 2*BW | Index register X |
| idx_y | output | 2*BW | Index register Y |
| sp | output | AW | Stack pointer |
| ccr | output | 4 | Flags {N,Z,V,C} |

## Verification
The hardest case to reach from the ports is a request that arrives while a memory operation is still in flight. The stimulus raises a clear-A request during the middle cycle of a byte load. The test passes only if the load's value survives and no extra completion appears in the scoreboard. Carry preservation is also hard to reach, because a set C can only come in through the A-to-flags transfer. The sequence therefore loads a flag pattern with C=1 before the loads and transfers that must keep C.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [2:0] {
    OP_CLR   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_XFER  = 3'd3,
    OP_EXCH  = 3'd4,
    OP_PUSH  = 3'd5,
    OP_PULL  = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR1,
    ST_WR2,
    ST_RD1,
    ST_RD2,
    ST_RCAP
  } seq_e;

  function automatic logic op_writes(op_e op, logic [1:0] sel);
    return (op == OP_STORE) || (op == OP_PUSH) || (op == OP_CLR && sel[1]);
  endfunction

  function automatic logic op_reads(op_e op);
    return (op == OP_LOAD) || (op == OP_PULL);
  endfunction

  function automatic logic op_wide(op_e op, logic [1:0] sel);
    return ((op == OP_LOAD) || (op == OP_STORE)) && sel[1];
  endfunction

endpackage

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  op_e           req_op,
  input  logic [1:0]    req_sel,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  input  logic [AW-1:0] sp,
  output logic          req_ready,
  output logic          fire,
  output op_e           cur_op,
  output logic [1:0]    cur_sel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [BW-1:0] mem_wdata,
  output logic          cap_hi,
  output logic          cap_fin,
  output logic          sp_dec,
  output logic          done
);

  seq_e          state_q;
  logic [BW-1:0] first_byte;

  assign req_ready = (state_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign cap_hi    = (state_q == ST_RD2);
  assign cap_fin   = (state_q == ST_RCAP);
  assign sp_dec    = (state_q == ST_WR1) && (cur_op == OP_PUSH);

  // first byte to write: zero for a clear, B only when sel picks B alone
  always_comb begin
    if (req_op == OP_CLR)
      first_byte = '0;
    else if (req_sel == 2'b01)
      first_byte = acc_b;
    else
      first_byte = acc_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cur_op    <= OP_NOP;
      cur_sel   <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fire) begin
            cur_op  <= req_op;
            cur_sel <= req_sel;
            if (op_writes(req_op, req_sel)) begin
              mem_we    <= 1'b1;
              mem_addr  <= (req_op == OP_PUSH) ? sp : req_addr;
              mem_wdata <= first_byte;
              state_q   <= ST_WR1;
            end else if (op_reads(req_op)) begin
              mem_re   <= 1'b1;
              mem_addr <= (req_op == OP_PULL) ? sp + AW'(1) : req_addr;
              state_q  <= ST_RD1;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_WR1: begin
          if (op_wide(cur_op, cur_sel)) begin
            mem_addr  <= mem_addr + AW'(1);
            mem_wdata <= acc_b;
            state_q   <= ST_WR2;
          end else begin
            mem_we  <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR2: begin
          mem_we  <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RD1: begin
          if (op_wide(cur_op, cur_sel)) begin
            mem_addr <= mem_addr + AW'(1);
            state_q  <= ST_RD2;
          end else begin
            mem_re  <= 1'b0;
            state_q <= ST_RCAP;
          end
        end
        ST_RD2: begin
          mem_re  <= 1'b0;
          state_q <= ST_RCAP;
        end
        ST_RCAP: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/amu_regfile.sv
module amu_regfile
  import amu_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            BW      = 8,
  parameter logic [AW-1:0] SP_INIT = 'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  op_e             req_op,
  input  logic [1:0]      req_sel,
  input  op_e             cur_op,
  input  logic [1:0]      cur_sel,
  input  logic            cap_hi,
  input  logic            cap_fin,
  input  logic            sp_dec,
  input  logic [BW-1:0]   mem_rdata,
  output logic [BW-1:0]   acc_a,
  output logic [BW-1:0]   acc_b,
  output logic [2*BW-1:0] idx_x,
  output logic [2*BW-1:0] idx_y,
  output logic [AW-1:0]   sp,
  output flags_t          flags
);

  localparam int IW     = 2 * BW;
  localparam int NUM_IX = 2;

  logic [IW-1:0] idx_q [NUM_IX];
  logic [IW-1:0] d_pair;
  logic [BW-1:0] st_byte;
  logic          st_n;
  logic          st_z;

  assign d_pair  = {acc_a, acc_b};
  assign st_byte = (req_sel == 2'b01) ? acc_b : acc_a;
  assign st_n    = req_sel[1] ? acc_a[BW-1] : st_byte[BW-1];
  assign st_z    = req_sel[1] ? (d_pair == '0) : (st_byte == '0);

  // index registers: one slot per exchange target
  for (genvar gi = 0; gi < NUM_IX; gi++) begin : g_idx
    always_ff @(posedge clk) begin
      if (rst)
        idx_q[gi] <= '0;
      else if (fire && req_op == OP_EXCH && int'(req_sel[0]) == gi)
        idx_q[gi] <= d_pair;
    end
  end

  assign idx_x = idx_q[0];
  assign idx_y = idx_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
      sp    <= SP_INIT;
      flags <= '0;
    end else begin
      if (fire) begin
        case (req_op)
          OP_CLR: begin
            if (!req_sel[1]) begin
              if (req_sel[0]) acc_b <= '0;
              else            acc_a <= '0;
            end
            flags <= '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
          end
          OP_STORE: begin
            flags.n <= st_n;
            flags.z <= st_z;
            flags.v <= 1'b0;
          end
          OP_XFER: begin
            case (req_sel)
              2'd0: begin
                acc_b   <= acc_a;
                flags.n <= acc_a[BW-1];
                flags.z <= (acc_a == '0);
                flags.v <= 1'b0;
              end
              2'd1: begin
                acc_a   <= acc_b;
                flags.n <= acc_b[BW-1];
                flags.z <= (acc_b == '0);
                flags.v <= 1'b0;
              end
              2'd2: flags <= flags_t'(acc_a[3:0]);
              default: acc_a <= {{(BW-4){1'b0}}, flags};
            endcase
          end
          OP_EXCH: {acc_a, acc_b} <= idx_q[req_sel[0]];
          OP_PULL: sp <= sp + AW'(1);
          default: ;
        endcase
      end

      if (sp_dec)
        sp <= sp - AW'(1);

      if (cap_hi)
        acc_a <= mem_rdata;

      if (cap_fin) begin
        if (cur_op == OP_LOAD) begin
          if (cur_sel[1]) begin
            acc_b   <= mem_rdata;
            flags.n <= acc_a[BW-1];
            flags.z <= ({acc_a, mem_rdata} == '0);
          end else begin
            if (cur_sel[0]) acc_b <= mem_rdata;
            else            acc_a <= mem_rdata;
            flags.n <= mem_rdata[BW-1];
            flags.z <= (mem_rdata == '0);
          end
          flags.v <= 1'b0;
        end else begin
          if (cur_sel[0]) acc_b <= mem_rdata;
          else            acc_a <= mem_rdata;
        end
      end
    end
  end

endmodule

// File: rtl/acc_move_unit.sv
module acc_move_unit
  import amu_pkg::*;
#(
  parameter int            AW      = 16,
  parameter int            BW      = 8,
  parameter logic [AW-1:0] SP_INIT = 'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [1:0]      req_sel,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            done,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  output logic [BW-1:0]   acc_a,
  output logic [BW-1:0]   acc_b,
  output logic [2*BW-1:0] idx_x,
  output logic [2*BW-1:0] idx_y,
  output logic [AW-1:0]   sp,
  output logic [3:0]      ccr
);

  op_e        op_w;
  op_e        cur_op_w;
  logic [1:0] cur_sel_w;
  logic       fire_w;
  logic       cap_hi_w;
  logic       cap_fin_w;
  logic       sp_dec_w;
  flags_t     flags_w;

  assign op_w = op_e'(req_op);
  assign ccr  = flags_w;

  amu_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (op_w),
    .req_sel   (req_sel),
    .req_addr  (req_addr),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .sp        (sp),
    .req_ready (req_ready),
    .fire      (fire_w),
    .cur_op    (cur_op_w),
    .cur_sel   (cur_sel_w),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .cap_hi    (cap_hi_w),
    .cap_fin   (cap_fin_w),
    .sp_dec    (sp_dec_w),
    .done      (done)
  );

  amu_regfile #(.AW(AW), .BW(BW), .SP_INIT(SP_INIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire_w),
    .req_op    (op_w),
    .req_sel   (req_sel),
    .cur_op    (cur_op_w),
    .cur_sel   (cur_sel_w),
    .cap_hi    (cap_hi_w),
    .cap_fin   (cap_fin_w),
    .sp_dec    (sp_dec_w),
    .mem_rdata (mem_rdata),
    .acc_a     (acc_a),
    .acc_b     (acc_b),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .sp        (sp),
    .flags     (flags_w)
  );

endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          done,
  input logic          fire,
  input logic [2:0]    req_op,
  input logic [2:0]    cur_op,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp,
  input logic [3:0]    ccr
);

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R10

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R10

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (done && cur_op == 3'd0) |-> (ccr == 4'b0100)); // R2

  AST_WIDE_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R4

  AST_WIDE_READ_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R3

  AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cur_op == 3'd5) |-> (mem_addr == sp)); // R5

  AST_PULL_AT_SP: assert property (@(posedge clk) disable iff (rst)
    (mem_re && cur_op == 3'd6) |-> (mem_addr == sp)); // R6

  AST_STACK_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && (cur_op == 3'd5 || cur_op == 3'd6)) |=> $stable(ccr)); // R5 R6

  AST_EXCH_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    (fire && req_op == 3'd4) |=> $stable(ccr)); // R9

endmodule

bind acc_move_unit amu_checker #(.AW(AW)) u_amu_checker (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .fire      (fire_w),
  .req_op    (req_op),
  .cur_op    (cur_op_w),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .sp        (sp),
  .ccr       (ccr)
);

// File: tb/test_acc_move_unit.sv
module test_acc_move_unit;

  localparam int            AW  = 16;
  localparam int            BW  = 8;
  localparam logic [15:0]   SP0 = 16'h00FF;

  localparam logic [2:0] C_CLR = 3'd0, C_LOAD = 3'd1, C_STORE = 3'd2, C_XFER = 3'd3,
                         C_EXCH = 3'd4, C_PUSH = 3'd5, C_PULL = 3'd6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst;
  logic            req_valid;
  logic [2:0]      req_op;
  logic [1:0]      req_sel;
  logic [AW-1:0]   req_addr;
  logic            req_ready;
  logic            done;
  logic [AW-1:0]   mem_addr;
  logic            mem_we;
  logic            mem_re;
  logic [BW-1:0]   mem_wdata;
  logic [BW-1:0]   mem_rdata;
  logic [BW-1:0]   acc_a;
  logic [BW-1:0]   acc_b;
  logic [2*BW-1:0] idx_x;
  logic [2*BW-1:0] idx_y;
  logic [AW-1:0]   sp;
  logic [3:0]      ccr;

  acc_move_unit #(.AW(AW), .BW(BW), .SP_INIT(SP0)) i_acc_move_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel),
    .req_addr(req_addr), .req_ready(req_ready), .done(done), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y), .sp(sp), .ccr(ccr)
  );

  // synchronous byte memory with a bench preload port
  logic [7:0] mem [0:255];
  logic       tb_we;
  logic [7:0] tb_addr;
  logic [7:0] tb_wd;

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_wd;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  // reference state built from the requirements
  logic [7:0]  emem [0:255];
  logic [7:0]  ma, mb;
  logic [15:0] mx, my, msp;
  logic [3:0]  mf;

  typedef struct {
    string       tag;
    logic [67:0] st;
  } exp_t;
  exp_t q[$];

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on each completion
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 68'd1, 68'd0);
      end else begin
        exp_t e;
        logic [67:0] act;
        e = q.pop_front();
        act = {acc_a, acc_b, idx_x, idx_y, sp, ccr};
        check(act == e.st, e.tag, act, e.st);
      end
    end
  end

  task automatic set_nz16(input logic [15:0] v);
    mf = {v[15], (v == 16'h0), 1'b0, mf[0]};
  endtask

  task automatic set_nz8(input logic [7:0] v);
    mf = {v[7], (v == 8'h0), 1'b0, mf[0]};
  endtask

  task automatic model(input logic [2:0] op, input logic [1:0] sel, input logic [7:0] ea);
    logic [15:0] t;
    case (op)
      C_CLR: begin
        if (sel[1]) emem[ea] = 8'h00;
        else if (sel[0]) mb = 8'h00;
        else ma = 8'h00;
        mf = 4'b0100;
      end
      C_LOAD: begin
        if (sel[1]) begin
          ma = emem[ea]; mb = emem[ea + 8'd1]; set_nz16({ma, mb});
        end else if (sel[0]) begin
          mb = emem[ea]; set_nz8(mb);
        end else begin
          ma = emem[ea]; set_nz8(ma);
        end
      end
      C_STORE: begin
        if (sel[1]) begin
          emem[ea] = ma; emem[ea + 8'd1] = mb; set_nz16({ma, mb});
        end else if (sel[0]) begin
          emem[ea] = mb; set_nz8(mb);
        end else begin
          emem[ea] = ma; set_nz8(ma);
        end
      end
      C_XFER: begin
        case (sel)
          2'd0: begin mb = ma; set_nz8(ma); end
          2'd1: begin ma = mb; set_nz8(mb); end
          2'd2: mf = ma[3:0];
          default: ma = {4'h0, mf};
        endcase
      end
      C_EXCH: begin
        t = {ma, mb};
        if (sel[0]) begin {ma, mb} = my; my = t; end
        else begin {ma, mb} = mx; mx = t; end
      end
      C_PUSH: begin
        emem[msp[7:0]] = sel[0] ? mb : ma;
        msp = msp - 16'd1;
      end
      C_PULL: begin
        msp = msp + 16'd1;
        if (sel[0]) mb = emem[msp[7:0]];
        else ma = emem[msp[7:0]];
      end
      default: ;
    endcase
  endtask

  // driver: update the model, queue the expectation, run the request
  task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [7:0] ea,
                       input string tag, input int exp_lat, input bit poke_busy);
    exp_t e;
    int lat;
    model(op, sel, ea);
    e.tag = tag;
    e.st  = {ma, mb, mx, my, msp, mf};
    q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sel = sel; req_addr = {8'h00, ea};
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && lat < 20) begin
      if (poke_busy && lat == 1) begin
        // R10: clear-A request while busy must be dropped
        req_valid = 1'b1; req_op = C_CLR; req_sel = 2'd0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    check(lat == exp_lat, {"R10 latency ", tag}, 68'(lat), 68'(exp_lat));
  endtask

  task automatic check_mem(input logic [7:0] a, input string tag);
    check(mem[a] == emem[a], tag, 68'(mem[a]), 68'(emem[a]));
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] v);
    tb_we = 1'b1; tb_addr = a; tb_wd = v; emem[a] = v;
    @(posedge clk);
    #1 tb_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_sel = '0; req_addr = '0;
    tb_we = 1'b0; tb_addr = '0; tb_wd = '0;
    ma = 0; mb = 0; mx = 0; my = 0; msp = SP0; mf = 0;
    for (int i = 0; i < 256; i++) preload(8'(i), 8'h00);
    preload(8'h10, 8'h80);
    preload(8'h11, 8'h00);
    preload(8'h12, 8'h7F);
    preload(8'h13, 8'h0B);
    preload(8'h20, 8'h12);
    preload(8'h21, 8'h34);
    preload(8'h33, 8'h55);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(acc_a == 8'h00, "R1 reset A", 68'(acc_a), 68'd0);
    check(acc_b == 8'h00, "R1 reset B", 68'(acc_b), 68'd0);
    check(idx_x == 16'h0 && idx_y == 16'h0, "R1 reset X Y", 68'({idx_x, idx_y}), 68'd0);
    check(sp == SP0, "R1 reset SP", 68'(sp), 68'(SP0));
    check(ccr == 4'h0, "R1 reset flags", 68'(ccr), 68'd0);
    check(req_ready == 1'b1 && done == 1'b0, "R1 reset handshake", 68'({req_ready, done}), 68'b10);

    issue(C_LOAD,  2'd0, 8'h13, "R3 load A",               3, 0);
    issue(C_XFER,  2'd2, 8'h00, "R8 A to flags",           1, 0);
    issue(C_LOAD,  2'd1, 8'h10, "R3 load B keeps C",       3, 0);
    issue(C_XFER,  2'd1, 8'h00, "R7 B to A",               1, 0);
    issue(C_XFER,  2'd3, 8'h00, "R8 flags to A",           1, 0);
    issue(C_LOAD,  2'd2, 8'h20, "R3 load D",               4, 0);
    issue(C_EXCH,  2'd0, 8'h00, "R9 swap D X",             1, 0);
    issue(C_LOAD,  2'd2, 8'h11, "R3 load D zero high",     4, 0);
    issue(C_EXCH,  2'd1, 8'h00, "R9 swap D Y",             1, 0);
    issue(C_EXCH,  2'd0, 8'h00, "R9 swap D X back",        1, 0);
    issue(C_STORE, 2'd2, 8'h30, "R4 store D",              3, 0);
    check_mem(8'h30, "R4 store D high byte");
    check_mem(8'h31, "R4 store D low byte");
    issue(C_XFER,  2'd0, 8'h00, "R7 A to B",               1, 0);
    issue(C_STORE, 2'd1, 8'h32, "R4 store B",              2, 0);
    check_mem(8'h32, "R4 store B byte");
    issue(C_CLR,   2'd0, 8'h00, "R2 clear A",              1, 0);
    issue(C_STORE, 2'd0, 8'h33, "R4 store A zero",         2, 0);
    check_mem(8'h33, "R4 store A byte");
    issue(C_CLR,   2'd2, 8'h30, "R2 clear memory",         2, 0);
    check_mem(8'h30, "R2 cleared byte");
    check_mem(8'h31, "R2 neighbour untouched");
    issue(C_LOAD,  2'd0, 8'h10, "R3 load A negative",      3, 0);
    issue(C_PUSH,  2'd0, 8'h00, "R5 push A",               2, 0);
    check_mem(8'hFF, "R5 push A byte at old SP");
    issue(C_PUSH,  2'd1, 8'h00, "R5 push B",               2, 0);
    check_mem(8'hFE, "R5 push B byte at old SP");
    issue(C_CLR,   2'd1, 8'h00, "R2 clear B",              1, 0);
    issue(C_PULL,  2'd0, 8'h00, "R6 pull A",               3, 0);
    issue(C_PULL,  2'd1, 8'h00, "R6 pull B",               3, 0);
    issue(C_LOAD,  2'd0, 8'h12, "R10 busy request ignored", 3, 1);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R10 scoreboard drained", 68'(q.size()), 68'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule